// File: doc/BRIEF.md
# Processor-to-ISA I/O Address Translator

This block sits between a processor's memory-mapped bus and a 16-bit ISA-style I/O port space. A processor access that lands in an 8 MB I/O window is turned into a single downstream port transaction. The port address is derived from the window offset in one of two ways, chosen by a map-mode input. In contiguous mode the offset is truncated to 64 KB. In sparse mode every 4 KB page of the window carries 32 ports. The size of the transfer (1, 2 or 4 bytes) is forwarded unchanged. Data crosses the bridge with its byte order converted: upstream values have the lowest-addressed byte most significant, and downstream values have it in the least significant lane.

The block also answers a small interrupt-acknowledge location. A read of its first byte returns the vector currently offered by the interrupt controller and pulses an acknowledge back to it. Any access that hits neither region completes locally at once with zero data.

A controller built around an enumerated state machine sequences each access. The states are:
- `ST_IDLE`: waits for a request.
- `ST_ISSUE`: drives the downstream request until it is taken.
- `ST_DONE`: returns the downstream result.
- `ST_LOCAL`: completes a miss.
- `ST_IACK`: completes an interrupt-acknowledge access.

The transitions are:
- `ST_IDLE` to `ST_ISSUE` on a window hit.
- `ST_IDLE` to `ST_IACK` on an acknowledge-region hit.
- `ST_IDLE` to `ST_LOCAL` on any other request.
- `ST_ISSUE` to `ST_DONE` when `io_ready` is seen.
- `ST_DONE`, `ST_LOCAL` and `ST_IACK` each back to `ST_IDLE` after one cycle.

The requester holds `cpu_req` and its fields until it sees `cpu_ready`, and drops `cpu_req` before the following clock edge.

Top module: `io_window_bridge`

## Requirements
- R1: `io_valid` is raised only for a request whose address lies in [0x80000000, 0x80800000) and whose size code is 0 (1 byte), 1 (2 bytes) or 2 (4 bytes). The window offset is the address minus 0x80000000.
- R2: With `map_sparse` = 0, `io_addr` equals bits [15:0] of the window offset.
- R3: With `map_sparse` = 1, `io_addr` bits [4:0] are offset bits [4:0] and `io_addr` bits [15:5] are offset bits [22:12]. Offset bits [11:5] are dropped.
- R4: `io_size` repeats `cpu_size`. Write data arrives right-justified with the lowest-addressed byte most significant. It leaves on `io_wdata` with the lowest-addressed byte in bits [7:0], the byte order reversed within the transfer size, and unused upper lanes zero.
- R5: Read data on `io_rdata` is taken as right-justified little-endian. It is returned on `cpu_rdata` with its byte order reversed within the transfer size and the lanes above the size cleared. A window write completes with `cpu_rdata` = 0.
- R6: `io_valid` stays high, with `io_addr`, `io_size`, `io_we` and `io_wdata` stable, until `io_ready`. `cpu_ready` is a one-cycle pulse in the cycle after the handshake, so a window access completes 2 + (wait cycles) cycles after it is accepted.
- R7: A read of 0xBFFFFFF0 completes one cycle after acceptance. It returns `irq_vector` zero-extended on `cpu_rdata`, with `irq_ack` high for that single cycle together with `cpu_ready`.
- R8: Reads of 0xBFFFFFF1 to 0xBFFFFFF3 return 0 without `irq_ack`. Writes anywhere in 0xBFFFFFF0 to 0xBFFFFFF3 complete with 0, with no `irq_ack` and no downstream request.
- R9: Any other request, including a window address with size code 3, makes no downstream request. It completes one cycle after acceptance with `cpu_rdata` = 0.
- R10: In reset, `io_valid`, `cpu_ready` and `irq_ack` are low. `cpu_rdata` is 0 whenever `cpu_ready` is low.
- R11: The map mode and the request fields are captured when the request is accepted. A change of `map_sparse` while a downstream request waits does not alter `io_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 reserved |
| cpu_wdata | input | 32 | Write data, right-justified, big-endian order |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| map_sparse | input | 1 | Map mode: 0 contiguous, 1 sparse |
| io_valid | output | 1 | Downstream port request |
| io_ready | input | 1 | Downstream accepts and completes the request |
| io_we | output | 1 | Downstream write |
| io_addr | output | 16 | Downstream port address |
| io_size | output | 2 | Downstream size code |
| io_wdata | output | 32 | Downstream write data, little-endian |
| io_rdata | input | 32 | Downstream read data, sampled with `io_ready` |
| irq_vector | input | 8 | Vector offered by the interrupt controller |
| irq_ack | output | 1 | One-cycle acknowledge to the interrupt controller |

## Verification
The assertions check the following on every cycle:
- The downstream request holds its fields stable while it waits.
- `io_valid` only ever appears for a window address with a legal size.
- Completion follows the handshake by one cycle and lasts one cycle.
- The acknowledge pulse is single, and only for a read at the head of the acknowledge location.
- Read data is zero outside completions.

Only the bench's scenarios can show that the port address follows each remap formula. The same holds for the byte-lane reversal for each transfer size, and for masking of unused read lanes. The bench scenarios also cover:
- The latency for different downstream wait lengths.
- The window and acknowledge-region edges.
- The reserved size code.
- Indifference to a mode change in mid-transaction.

// File: rtl/iob_pkg.sv
package iob_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_DONE  = 3'd2,
        ST_LOCAL = 3'd3,
        ST_IACK  = 3'd4
    } iob_state_e;

    typedef enum logic [1:0] {
        RG_MISS = 2'd0,
        RG_WIN  = 2'd1,
        RG_IACK = 2'd2
    } iob_region_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_RSVD = 2'd3;

endpackage

// File: rtl/iob_region_decode.sv
module iob_region_decode
    import iob_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              WIN_LOG2  = 23,
    parameter int              IACK_LOG2 = 2,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] IACK_BASE = 32'hBFFF_FFF0
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          size,
    output iob_region_e         region,
    output logic [WIN_LOG2-1:0] win_off,
    output logic                iack_head
);

    logic win_tag_hit;
    logic iack_tag_hit;

    // Window and acknowledge regions are naturally aligned to their size.
    assign win_tag_hit  = (addr[ADDR_W-1:WIN_LOG2]  == WIN_BASE[ADDR_W-1:WIN_LOG2]);
    assign iack_tag_hit = (addr[ADDR_W-1:IACK_LOG2] == IACK_BASE[ADDR_W-1:IACK_LOG2]);

    assign win_off   = addr[WIN_LOG2-1:0];
    assign iack_head = iack_tag_hit && (addr[IACK_LOG2-1:0] == '0);

    always_comb begin
        if (win_tag_hit && (size != SZ_RSVD)) begin
            region = RG_WIN;
        end else if (iack_tag_hit) begin
            region = RG_IACK;
        end else begin
            region = RG_MISS;
        end
    end

endmodule

// File: rtl/iob_addr_remap.sv
module iob_addr_remap #(
    parameter int WIN_LOG2    = 23,
    parameter int PORT_W      = 16,
    parameter int SPARSE_LOW  = 5,
    parameter int SPARSE_PAGE = 12
) (
    input  logic [WIN_LOG2-1:0] off,
    input  logic                sparse,
    output logic [PORT_W-1:0]   port
);

    localparam int HI_W = WIN_LOG2 - SPARSE_PAGE;
    localparam int SP_W = HI_W + SPARSE_LOW;

    logic [PORT_W-1:0] port_contig;
    logic [PORT_W-1:0] port_sparse;
    logic [SP_W-1:0]   sparse_raw;

    // Contiguous: plain truncation of the offset.
    generate
        if (PORT_W <= WIN_LOG2) begin : g_contig_trunc
            assign port_contig = off[PORT_W-1:0];
        end else begin : g_contig_ext
            assign port_contig = {{(PORT_W-WIN_LOG2){1'b0}}, off};
        end
    endgenerate

    // Sparse: keep the low port bits, pull the page number down beside them.
    assign sparse_raw = {off[WIN_LOG2-1:SPARSE_PAGE], off[SPARSE_LOW-1:0]};

    generate
        if (SP_W >= PORT_W) begin : g_sparse_trunc
            assign port_sparse = sparse_raw[PORT_W-1:0];
        end else begin : g_sparse_ext
            assign port_sparse = {{(PORT_W-SP_W){1'b0}}, sparse_raw};
        end
    endgenerate

    assign port = sparse ? port_sparse : port_contig;

endmodule

// File: rtl/iob_lane_swap.sv
module iob_lane_swap
    import iob_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] dout
);

    localparam int NB = DATA_W / 8;

    // Reverses byte order within the transfer size and clears unused lanes.
    // The mapping is its own inverse, so one instance serves each direction.
    generate
        for (genvar i = 0; i < NB; i++) begin : g_lane
            logic [7:0] b_byte;
            logic [7:0] b_half;
            logic [7:0] b_word;

            if (i == 0) begin : g_b0
                assign b_byte = din[7:0];
            end else begin : g_bz
                assign b_byte = 8'h00;
            end

            if (i < 2) begin : g_h
                assign b_half = din[8*(1-i) +: 8];
            end else begin : g_hz
                assign b_half = 8'h00;
            end

            assign b_word = din[8*(NB-1-i) +: 8];

            assign dout[8*i +: 8] = (size == SZ_BYTE) ? b_byte :
                                    (size == SZ_HALF) ? b_half : b_word;
        end
    endgenerate

endmodule

// File: rtl/io_window_bridge.sv
module io_window_bridge
    import iob_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter int                PORT_W      = 16,
    parameter int                VEC_W       = 8,
    parameter int                WIN_LOG2    = 23,
    parameter int                IACK_LOG2   = 2,
    parameter int                SPARSE_LOW  = 5,
    parameter int                SPARSE_PAGE = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE    = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] IACK_BASE   = 32'hBFFF_FFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              map_sparse,
    output logic              io_valid,
    input  logic              io_ready,
    output logic              io_we,
    output logic [PORT_W-1:0] io_addr,
    output logic [1:0]        io_size,
    output logic [DATA_W-1:0] io_wdata,
    input  logic [DATA_W-1:0] io_rdata,
    input  logic [VEC_W-1:0]  irq_vector,
    output logic              irq_ack
);

    iob_state_e          state_q;
    iob_state_e          state_d;
    iob_region_e         region;
    logic [WIN_LOG2-1:0] win_off;
    logic                iack_head;
    logic [PORT_W-1:0]   port_xl;
    logic [DATA_W-1:0]   wdata_le;
    logic [DATA_W-1:0]   rdata_be;
    logic                accept;
    logic                vec_read;

    logic [PORT_W-1:0]   io_addr_q;
    logic [1:0]          io_size_q;
    logic                io_we_q;
    logic [DATA_W-1:0]   io_wdata_q;
    logic [DATA_W-1:0]   rdata_q;
    logic                ack_q;

    iob_region_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_LOG2 (WIN_LOG2),
        .IACK_LOG2(IACK_LOG2),
        .WIN_BASE (WIN_BASE),
        .IACK_BASE(IACK_BASE)
    ) u_decode (
        .addr     (cpu_addr),
        .size     (cpu_size),
        .region   (region),
        .win_off  (win_off),
        .iack_head(iack_head)
    );

    iob_addr_remap #(
        .WIN_LOG2   (WIN_LOG2),
        .PORT_W     (PORT_W),
        .SPARSE_LOW (SPARSE_LOW),
        .SPARSE_PAGE(SPARSE_PAGE)
    ) u_remap (
        .off   (win_off),
        .sparse(map_sparse),
        .port  (port_xl)
    );

    iob_lane_swap #(.DATA_W(DATA_W)) u_swap_wr (
        .din (cpu_wdata),
        .size(cpu_size),
        .dout(wdata_le)
    );

    iob_lane_swap #(.DATA_W(DATA_W)) u_swap_rd (
        .din (io_rdata),
        .size(io_size_q),
        .dout(rdata_be)
    );

    assign accept   = (state_q == ST_IDLE) && cpu_req;
    assign vec_read = (region == RG_IACK) && !cpu_we && iack_head;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    unique case (region)
                        RG_WIN:  state_d = ST_ISSUE;
                        RG_IACK: state_d = ST_IACK;
                        default: state_d = ST_LOCAL;
                    endcase
                end
            end
            ST_ISSUE: begin
                if (io_ready) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_LOCAL: state_d = ST_IDLE;
            ST_IACK:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- captured transaction ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_addr_q  <= '0;
            io_size_q  <= SZ_BYTE;
            io_we_q    <= 1'b0;
            io_wdata_q <= '0;
            rdata_q    <= '0;
            ack_q      <= 1'b0;
        end else if (accept) begin
            io_addr_q  <= port_xl;
            io_size_q  <= cpu_size;
            io_we_q    <= cpu_we;
            io_wdata_q <= cpu_we ? wdata_le : '0;
            ack_q      <= vec_read;
            rdata_q    <= vec_read ? DATA_W'(irq_vector) : '0;
        end else if ((state_q == ST_ISSUE) && io_ready) begin
            rdata_q    <= io_we_q ? '0 : rdata_be;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        io_valid  = 1'b0;
        cpu_ready = 1'b0;
        irq_ack   = 1'b0;
        cpu_rdata = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ISSUE: begin
                io_valid = 1'b1;
            end
            ST_DONE, ST_LOCAL: begin
                cpu_ready = 1'b1;
                cpu_rdata = rdata_q;
            end
            ST_IACK: begin
                cpu_ready = 1'b1;
                cpu_rdata = rdata_q;
                irq_ack   = ack_q;
            end
            default: begin
            end
        endcase
    end

    assign io_addr  = io_addr_q;
    assign io_size  = io_size_q;
    assign io_we    = io_we_q;
    assign io_wdata = io_wdata_q;

endmodule

// File: rtl/iob_checker.sv
module iob_checker #(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter int                PORT_W    = 16,
    parameter int                WIN_LOG2  = 23,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] IACK_BASE = 32'hBFFF_FFF0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [1:0]        cpu_size,
    input logic              cpu_ready,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              io_valid,
    input logic              io_ready,
    input logic              io_we,
    input logic [PORT_W-1:0] io_addr,
    input logic [1:0]        io_size,
    input logic [DATA_W-1:0] io_wdata,
    input logic              irq_ack
);

    AST_ISSUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid && !io_ready |=> io_valid && $stable(io_addr) && $stable(io_size)
                                  && $stable(io_we) && $stable(io_wdata)); // R6

    AST_DONE_AFTER_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid && io_ready |=> cpu_ready && !io_valid); // R6

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready); // R6

    AST_IO_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> cpu_req && (cpu_addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2])
                     && (cpu_size != 2'd3)); // R1

    AST_ACK_HEAD_READ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> cpu_ready && !cpu_we && (cpu_addr == IACK_BASE)); // R7

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack); // R7

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |-> (cpu_rdata == '0)); // R10

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!io_valid && !cpu_ready && !irq_ack); // R10
        end
    end

endmodule

bind io_window_bridge iob_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PORT_W   (PORT_W),
    .WIN_LOG2 (WIN_LOG2),
    .WIN_BASE (WIN_BASE),
    .IACK_BASE(IACK_BASE)
) u_iob_checker (.*);

// File: tb/io_window_bridge_bench.sv
module io_window_bridge_bench;

    typedef struct {
        logic [15:0] port;
        logic [1:0]  size;
        logic        we;
        logic [31:0] wdata;
        logic [31:0] rdata;
        string       tag;
    } io_item_t;

    typedef struct {
        logic [31:0] rdata;
        logic        ack;
        string       tag;
    } rsp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        map_sparse = 1'b0;
    logic        io_valid;
    logic        io_ready = 1'b0;
    logic        io_we;
    logic [15:0] io_addr;
    logic [1:0]  io_size;
    logic [31:0] io_wdata;
    logic [31:0] io_rdata = '0;
    logic [7:0]  irq_vector = 8'h5A;
    logic        irq_ack;

    int tests = 0;
    int fails = 0;
    int dn_dly = 0;
    int wcnt = 0;
    int wd = 0;
    io_item_t  io_q[$];
    rsp_item_t rsp_q[$];

    always #2.5 clk = ~clk;

    io_window_bridge u_io_window_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_size  (cpu_size),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .map_sparse(map_sparse),
        .io_valid  (io_valid),
        .io_ready  (io_ready),
        .io_we     (io_we),
        .io_addr   (io_addr),
        .io_size   (io_size),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .irq_vector(irq_vector),
        .irq_ack   (irq_ack)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_port(input logic [31:0] a, input logic sp);
        logic [31:0] off;
        logic [31:0] p;
        off = a - 32'h8000_0000;
        if (sp) p = (off & 32'h0000_001F) | ((off & 32'h007F_F000) >> 7);
        else    p = off & 32'h0000_FFFF;
        return p[15:0];
    endfunction

    function automatic logic [31:0] le_swap(input logic [31:0] d, input logic [1:0] sz);
        case (sz)
            2'd0:    return {24'h0, d[7:0]};
            2'd1:    return {16'h0, d[7:0], d[15:8]};
            default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
        endcase
    endfunction

    // Driver: pushes the expected downstream item and response, then runs the access.
    task automatic access(input logic [31:0] a, input logic we, input logic [1:0] sz,
                          input logic [31:0] wd_in, input logic [31:0] dn_data,
                          input int dly, input bit flip, input string tag);
        bit        to_io;
        int        cyc;
        int        exp_cyc;
        io_item_t  it;
        rsp_item_t rs;
        to_io = (a >= 32'h8000_0000) && (a < 32'h8080_0000) && (sz != 2'd3);
        rs.ack = !we && (a == 32'hBFFF_FFF0);
        if (to_io) rs.rdata = we ? 32'h0 : le_swap(dn_data, sz);
        else       rs.rdata = rs.ack ? {24'h0, irq_vector} : 32'h0;
        rs.tag = tag;
        if (to_io) begin
            it.port  = exp_port(a, map_sparse);
            it.size  = sz;
            it.we    = we;
            it.wdata = we ? le_swap(wd_in, sz) : 32'h0;
            it.rdata = dn_data;
            it.tag   = tag;
            io_q.push_back(it);
        end
        rsp_q.push_back(rs);
        exp_cyc = to_io ? 2 + dly : 1;
        dn_dly  = dly;
        @(negedge clk);
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_size  = sz;
        cpu_wdata = wd_in;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (flip && cyc == 1) map_sparse = ~map_sparse;
        end while (!cpu_ready && cyc < 50);
        cpu_req = 1'b0;
        if (flip) map_sparse = ~map_sparse;
        check(cyc == exp_cyc, tag, "completion latency", 32'(cyc), 32'(exp_cyc));
    endtask

    // Downstream responder and monitor.
    always @(negedge clk) begin
        if (io_ready) begin
            io_ready = 1'b0;
            wcnt = 0;
        end else if (io_valid) begin
            if (io_q.size() == 0) begin
                check(1'b0, "R1/R9", "unexpected downstream request", {16'h0, io_addr}, 32'h0);
            end else begin
                check(io_addr == io_q[0].port, io_q[0].tag, "io_addr", {16'h0, io_addr}, {16'h0, io_q[0].port});
                check(io_size == io_q[0].size, io_q[0].tag, "io_size (R4)", {30'h0, io_size}, {30'h0, io_q[0].size});
                check(io_we == io_q[0].we, io_q[0].tag, "io_we", {31'h0, io_we}, {31'h0, io_q[0].we});
                if (io_q[0].we)
                    check(io_wdata == io_q[0].wdata, io_q[0].tag, "io_wdata (R4)", io_wdata, io_q[0].wdata);
                if (wcnt == dn_dly) begin
                    io_ready = 1'b1;
                    io_rdata = io_q[0].rdata;
                    void'(io_q.pop_front());
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // Upstream monitor.
    always @(negedge clk) begin
        if (rst_n && cpu_ready) begin
            if (rsp_q.size() == 0) begin
                check(1'b0, "R6", "unexpected cpu_ready", cpu_rdata, 32'h0);
            end else begin
                rsp_item_t r;
                r = rsp_q.pop_front();
                check(cpu_rdata == r.rdata, r.tag, "cpu_rdata", cpu_rdata, r.rdata);
                check(irq_ack == r.ack, r.tag, "irq_ack (R7)", {31'h0, irq_ack}, {31'h0, r.ack});
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!io_valid && !cpu_ready && !irq_ack, "R10", "outputs in reset",
              {29'h0, io_valid, cpu_ready, irq_ack}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!io_valid && !cpu_ready && cpu_rdata == 32'h0, "R10", "idle after reset",
              cpu_rdata, 32'h0);

        map_sparse = 1'b0;
        access(32'h8000_1234, 1'b1, 2'd0, 32'h0000_00A5, 32'h0, 0, 1'b0, "R2 R4 byte write");
        access(32'h807F_0092, 1'b1, 2'd1, 32'h0000_1234, 32'h0, 1, 1'b0, "R2 R4 half write");
        access(32'h8000_0400, 1'b0, 2'd2, 32'h0, 32'hDDCC_BBAA, 0, 1'b0, "R5 word read");
        access(32'h8000_0061, 1'b0, 2'd0, 32'h0, 32'h1234_56C3, 2, 1'b0, "R5 byte read");
        access(32'h807F_FFFF, 1'b0, 2'd0, 32'h0, 32'h0000_0077, 0, 1'b0, "R1 R2 window top");
        map_sparse = 1'b1;
        access(32'h8034_5678, 1'b1, 2'd2, 32'h1122_3344, 32'h0, 2, 1'b0, "R3 R4 word write");
        access(32'h807F_F01F, 1'b0, 2'd1, 32'h0, 32'hFFFF_BEEF, 3, 1'b0, "R3 R5 half read");
        access(32'h8000_2005, 1'b0, 2'd2, 32'h0, 32'h0102_0304, 4, 1'b1, "R11 mode flip");
        access(32'h8000_0000, 1'b1, 2'd1, 32'h0000_ABCD, 32'h0, 5, 1'b0, "R6 long wait");
        map_sparse = 1'b0;
        access(32'hBFFF_FFF0, 1'b0, 2'd2, 32'h0, 32'h0, 0, 1'b0, "R7 vector read");
        irq_vector = 8'hC1;
        access(32'hBFFF_FFF0, 1'b0, 2'd0, 32'h0, 32'h0, 0, 1'b0, "R7 second vector");
        access(32'hBFFF_FFF2, 1'b0, 2'd0, 32'h0, 32'h0, 0, 1'b0, "R8 off-head read");
        access(32'hBFFF_FFF0, 1'b1, 2'd2, 32'hFFFF_FFFF, 32'h0, 0, 1'b0, "R8 discarded write");
        access(32'h8080_0000, 1'b0, 2'd2, 32'h0, 32'h0, 0, 1'b0, "R9 past window");
        access(32'h7FFF_FFFF, 1'b1, 2'd0, 32'h55, 32'h0, 0, 1'b0, "R9 below window");
        access(32'h8000_0010, 1'b0, 2'd3, 32'h0, 32'h0, 0, 1'b0, "R9 reserved size");
        access(32'hBFFF_FFF4, 1'b0, 2'd2, 32'h0, 32'h0, 0, 1'b0, "R9 past ack region");

        repeat (4) @(negedge clk);
        check(io_q.size() == 0 && rsp_q.size() == 0, "R6", "scoreboard drained",
              32'(io_q.size() + rsp_q.size()), 32'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule